// File: doc/BRIEF.md
# Serial Flash Page-Write Sequencer

This block writes one buffer of 1 to 256 bytes into a serial NOR flash through a mode-0 SPI master of its own. The host gives a 24-bit start address and a byte count with a one-cycle start strobe. It then streams the payload over a valid/ready byte interface. The block first checks that the buffer fits between the start address and the end of its 256-byte page. If it does not fit, the block refuses the job instead of letting the flash wrap the address inside the page.

An accepted job runs as a fixed sequence of frames. The first frame is a lone write-enable opcode. After a short chip-select gap, the program frame follows: opcode, three address bytes and the payload. Chip select rises right after the last payload bit. The block then waits a programmable settle time and repeats a status-read frame until the busy flag clears. If the flag stays set for too many polls, the job ends with an error.

Top module: `spi_pp_seq`

## Requirements
- R1: A start with a count of 0, or with a count greater than 256 minus address bits [7:0], gives an error pulse on err_o in the next cycle. No frame is sent (cs_no stays high).
- R2: An accepted job first sends a frame that holds only the byte 0x06. Chip select rises after that frame, before the next frame starts.
- R3: The second frame is 0x02, then address bits [23:16], [15:8] and [7:0], then exactly the counted number of payload bytes in stream order. Chip select rises directly after the last payload byte.
- R4: A payload byte is taken only in a cycle where data_valid_i and data_ready_o are both high. data_ready_o is high only inside the program frame while no byte is being shifted. A low data_valid_i stalls the frame.
- R5: SPI mode 0: sclk_o is low whenever cs_no is high. Each byte goes out MSB first. mosi_o changes only while sclk_o is low, and miso_i is sampled on the rising edge.
- R6: After the program frame ends, chip select stays high for at least WAIT_CYCLES clock cycles before the first status frame.
- R7: Each status frame is the byte 0x05 followed by one read byte. Bit 0 of the read byte set means busy, and the other bits are ignored. While busy, the poll repeats after a chip-select gap.
- R8: When a poll reads bit 0 as 0, done_o pulses high for exactly one cycle and no further frame is sent.
- R9: If MAX_POLLS polls in a row all read busy, err_o pulses once and polling stops. No done_o is given.
- R10: done_o and err_o are never high together. A start strobe that arrives while a job is running is ignored and does not disturb that job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle job request |
| addr_i | input | 24 | Flash start address |
| len_i | input | 9 | Payload byte count (1..256) |
| data_i | input | 8 | Payload byte |
| data_valid_i | input | 1 | Payload byte is valid |
| data_ready_o | output | 1 | Block takes the payload byte this cycle |
| done_o | output | 1 | Job finished, flash no longer busy |
| err_o | output | 1 | Job rejected or poll limit reached |
| sclk_o | output | 1 | SPI clock, idles low |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to flash |
| miso_i | input | 1 | SPI data from flash |

## Verification
Most faults in the state register or the byte index show up as a wrong frame layout. A wrong frame layout means an extra or missing byte, an address byte out of order, or chip select staying low across what should be two frames. These appear on the SPI pins within one byte time, which is 16·CLK_DIV cycles. A wrong remaining-count or poll counter shows only at the end of a job: the payload length is off or done/err comes out wrong. A timer fault shows as a settle gap shorter than WAIT_CYCLES, which can be measured between the end of the program frame and the start of the first poll.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam int unsigned PAGE_BYTES = 256;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WREN, ST_GAP, ST_CMD, ST_DATA,
    ST_WAIT, ST_POLL, ST_DONE, ST_ERR
  } pp_state_e;
endpackage

// File: rtl/spi_pp_master.sv
module spi_pp_master #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          active_q, sclk_q, done_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        tx_q     <= tx_i;
        bit_q    <= '0;
        div_q    <= '0;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (div_q == DW'(CLK_DIV - 1)) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
endmodule

// File: rtl/spi_pp_len_chk.sv
module spi_pp_len_chk (
  input  logic [7:0] addr_lo_i,
  input  logic [8:0] len_i,
  output logic       ok_o
);
  logic [8:0] room;
  assign room = 9'd256 - {1'b0, addr_lo_i};
  assign ok_o = (len_i != 9'd0) && (len_i <= room);
endmodule

// File: rtl/spi_pp_fsm.sv
module spi_pp_fsm
  import spi_pp_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 10000,
  parameter int unsigned MAX_POLLS   = 4096,
  parameter int unsigned GAP_CYCLES  = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [23:0] addr_i,
  input  logic [8:0]  len_i,
  input  logic        len_ok_i,
  input  logic [7:0]  data_i,
  input  logic        data_valid_i,
  output logic        data_ready_o,
  input  logic        xfer_done_i,
  input  logic        busy_bit_i,
  output logic        go_o,
  output logic [7:0]  tx_o,
  output logic        cs_n_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int unsigned TMAX = (WAIT_CYCLES > GAP_CYCLES) ? WAIT_CYCLES : GAP_CYCLES;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned PW   = $clog2(MAX_POLLS + 1);

  pp_state_e     state_q, nxt_q;
  logic [1:0]    idx_q;
  logic [23:0]   addr_q;
  logic [8:0]    rem_q;
  logic [TW-1:0] tmr_q;
  logic [PW-1:0] polls_q;
  logic          pend_q;
  logic          byte_st;

  assign byte_st = (state_q == ST_WREN) || (state_q == ST_CMD) ||
                   (state_q == ST_DATA) || (state_q == ST_POLL);
  assign go_o = byte_st && !pend_q && ((state_q != ST_DATA) || data_valid_i);
  assign data_ready_o = (state_q == ST_DATA) && !pend_q;
  assign cs_n_o = !byte_st;
  assign done_o = (state_q == ST_DONE);
  assign err_o  = (state_q == ST_ERR);

  always_comb begin
    tx_o = 8'h00;
    unique case (state_q)
      ST_WREN: tx_o = OP_WREN;
      ST_CMD: begin
        unique case (idx_q)
          2'd0:    tx_o = OP_PROG;
          2'd1:    tx_o = addr_q[23:16];
          2'd2:    tx_o = addr_q[15:8];
          default: tx_o = addr_q[7:0];
        endcase
      end
      ST_DATA: tx_o = data_i;
      ST_POLL: tx_o = (idx_q == 2'd0) ? OP_STAT : 8'h00;
      default: tx_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      tmr_q   <= '0;
      polls_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (go_o)             pend_q <= 1'b1;
      else if (xfer_done_i) pend_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (len_ok_i) begin
            addr_q  <= addr_i;
            rem_q   <= len_i;
            polls_q <= '0;
            idx_q   <= '0;
            state_q <= ST_WREN;
          end else begin
            state_q <= ST_ERR;
          end
        end
        ST_WREN: if (xfer_done_i) begin
          state_q <= ST_GAP;
          nxt_q   <= ST_CMD;
          tmr_q   <= TW'(GAP_CYCLES - 1);
        end
        ST_GAP: begin
          if (tmr_q == '0) begin
            state_q <= nxt_q;
            idx_q   <= '0;
          end else begin
            tmr_q <= tmr_q - TW'(1);
          end
        end
        ST_CMD: if (xfer_done_i) begin
          if (idx_q == 2'd3) state_q <= ST_DATA;
          else               idx_q   <= idx_q + 2'd1;
        end
        ST_DATA: if (xfer_done_i) begin
          rem_q <= rem_q - 9'd1;
          if (rem_q == 9'd1) begin
            state_q <= ST_WAIT;
            tmr_q   <= TW'(WAIT_CYCLES - 1);
          end
        end
        ST_WAIT: begin
          if (tmr_q == '0) begin
            state_q <= ST_POLL;
            idx_q   <= '0;
          end else begin
            tmr_q <= tmr_q - TW'(1);
          end
        end
        ST_POLL: if (xfer_done_i) begin
          if (idx_q == 2'd0) begin
            idx_q <= 2'd1;
          end else if (!busy_bit_i) begin
            state_q <= ST_DONE;
          end else if (polls_q == PW'(MAX_POLLS - 1)) begin
            state_q <= ST_ERR;
          end else begin
            polls_q <= polls_q + PW'(1);
            state_q <= ST_GAP;
            nxt_q   <= ST_POLL;
            tmr_q   <= TW'(GAP_CYCLES - 1);
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        ST_ERR:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_pp_seq.sv
module spi_pp_seq #(
  parameter int unsigned CLK_DIV     = 4,
  parameter int unsigned WAIT_CYCLES = 10000,
  parameter int unsigned MAX_POLLS   = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [23:0] addr_i,
  input  logic [8:0]  len_i,
  input  logic [7:0]  data_i,
  input  logic        data_valid_i,
  output logic        data_ready_o,
  output logic        done_o,
  output logic        err_o,
  output logic        sclk_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int unsigned GAP_CYCLES = 2 * CLK_DIV;

  logic       len_ok, go, xfer_done;
  logic [7:0] tx_byte, rx_byte;

  spi_pp_len_chk u_len (
    .addr_lo_i (addr_i[7:0]),
    .len_i     (len_i),
    .ok_o      (len_ok)
  );

  spi_pp_fsm #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .MAX_POLLS   (MAX_POLLS),
    .GAP_CYCLES  (GAP_CYCLES)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .addr_i       (addr_i),
    .len_i        (len_i),
    .len_ok_i     (len_ok),
    .data_i       (data_i),
    .data_valid_i (data_valid_i),
    .data_ready_o (data_ready_o),
    .xfer_done_i  (xfer_done),
    .busy_bit_i   (rx_byte[0]),
    .go_o         (go),
    .tx_o         (tx_byte),
    .cs_n_o       (cs_no),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  spi_pp_master #(
    .CLK_DIV (CLK_DIV)
  ) u_spi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .tx_i   (tx_byte),
    .miso_i (miso_i),
    .done_o (xfer_done),
    .rx_o   (rx_byte),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o)
  );
endmodule

// File: rtl/spi_pp_seq_chk.sv
module spi_pp_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [7:0]  addr_lo_i,
  input logic [8:0]  len_i,
  input logic        data_ready_o,
  input logic        done_o,
  input logic        err_o,
  input logic        sclk_o,
  input logic        cs_no,
  input logic        mosi_o
);
  logic run_q, bad_len;
  assign bad_len = (len_i == 9'd0) || (len_i > (9'd256 - {1'b0, addr_lo_i}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= 1'b0;
    else if (done_o || err_o)           run_q <= 1'b0;
    else if (start_i && !bad_len)       run_q <= 1'b1;
  end

  AST_BAD_LEN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !run_q && bad_len |=> err_o); // R1
  AST_BAD_LEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !run_q && bad_len |=> cs_no); // R1
  AST_READY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> !cs_no); // R4
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R5
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R10
  AST_IDLE_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> cs_no); // R10
endmodule

bind spi_pp_seq spi_pp_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .addr_lo_i    (addr_i[7:0]),
  .len_i        (len_i),
  .data_ready_o (data_ready_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .sclk_o       (sclk_o),
  .cs_no        (cs_no),
  .mosi_o       (mosi_o)
);

// File: tb/tb_spi_pp_seq.sv
module tb_spi_pp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int WAITC = 40;
  localparam int MAXP  = 4;
  localparam int NVEC  = 8;

  // kind: 0 = completes, 1 = rejected length, 2 = poll limit
  localparam logic [23:0] V_ADDR [NVEC] = '{24'h123400, 24'hABCDF0, 24'h000000, 24'h0000F1,
                                            24'h000010, 24'h000055, 24'h0000FF, 24'h3456FF};
  localparam int V_LEN  [NVEC] = '{4, 16, 256, 16, 0, 3, 1, 2};
  localparam int V_BUSY [NVEC] = '{0, 2, 1, 0, 0, 4, 3, 0};
  localparam int V_KIND [NVEC] = '{0, 0, 0, 1, 1, 2, 0, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dvalid = 1'b0, miso;
  logic [23:0] addr = '0;
  logic [8:0]  len = '0;
  logic [7:0]  dat = '0;
  logic dready, done, err, sclk, cs_n, mosi;

  spi_pp_seq #(.CLK_DIV(DIV), .WAIT_CYCLES(WAITC), .MAX_POLLS(MAXP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
    .data_i(dat), .data_valid_i(dvalid), .data_ready_o(dready), .done_o(done),
    .err_o(err), .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [7:0] dbyte(input int k);
    return 8'(k * 29 + 90);
  endfunction

  // flash model and frame log
  logic [7:0] lg [512];
  int fst [16], fln [16], frise [16], ffall [16];
  int nb = 0, nfr = 0, bitc = 0, bif = 0, busy_left = 0;
  bit mon_en = 0, pollfr = 0;
  logic [7:0] sh = '0, stat = '0;

  assign miso = (pollfr && bif == 1 && bitc < 8) ? stat[7 - bitc] : 1'b0;

  always @(negedge cs_n) if (mon_en) begin
    if (nfr < 16) begin fst[nfr] = nb; ffall[nfr] = cyc; end
    bitc = 0; bif = 0; pollfr = 0;
  end
  always @(posedge cs_n) if (mon_en) begin
    if (nfr < 16) begin fln[nfr] = nb - fst[nfr]; frise[nfr] = cyc; end
    nfr++;
    if (pollfr && busy_left > 0) busy_left--;
  end
  always @(posedge sclk) if (mon_en && !cs_n) begin
    sh = {sh[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      if (nb < 512) lg[nb] = sh;
      nb++;
      bitc = 0;
      if (bif == 0 && sh == 8'h05) begin
        pollfr = 1;
        stat = (busy_left > 0) ? 8'hA1 : 8'hA0;
      end
      bif++;
    end
  end

  // payload feeder
  int done_cnt = 0, err_cnt = 0, fed = 0, feed_k = 0, feed_len = 0;
  bit feed_en = 0, xfer_pend = 0;
  always @(negedge clk) begin
    done_cnt += int'(done);
    err_cnt  += int'(err);
    if (xfer_pend) begin fed++; feed_k++; end
    dvalid = feed_en && (feed_k < feed_len) && (cyc % 5 != 3);
    dat = dbyte(feed_k);
    xfer_pend = dvalid && dready;
  end

  task automatic run_txn(input logic [23:0] a, input int n, input int busy, input bit inject);
    nb = 0; nfr = 0; busy_left = busy;
    done_cnt = 0; err_cnt = 0; fed = 0; feed_k = 0; feed_len = n; feed_en = 1;
    @(negedge clk);
    start = 1; addr = a; len = 9'(n);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 20000 && done_cnt + err_cnt == 0; i++) begin
      @(negedge clk);
      if (inject && i == 30) begin start = 1; len = 9'd0; end
      if (inject && i == 31) begin start = 0; len = 9'(n); end
    end
    repeat (12) @(negedge clk);
    feed_en = 0;
  endtask

  task automatic verify(input logic [23:0] a, input int n, input int busy, input int kind);
    int polls, bad;
    if (kind == 1) begin
      chk(err_cnt == 1, "R1 err pulse", err_cnt, 1);
      chk(nfr == 0 && done_cnt == 0, "R1 no frame", nfr, 0);
      return;
    end
    polls = (kind == 2) ? MAXP : busy + 1;
    chk(done_cnt == (kind == 0 ? 1 : 0), "R8 done count", done_cnt, kind == 0 ? 1 : 0);
    chk(err_cnt == (kind == 2 ? 1 : 0), "R9 err count", err_cnt, kind == 2 ? 1 : 0);
    chk(fed == n, "R4 bytes taken", fed, n);
    chk(nfr == 2 + polls, "R7 frame count", nfr, 2 + polls);
    chk(fln[0] == 1 && lg[0] == 8'h06, "R2 wren frame", int'(lg[0]), 6);
    chk(ffall[1] > frise[0], "R2 cs gap", ffall[1] - frise[0], 1);
    chk(fln[1] == 4 + n, "R3 prog length", fln[1], 4 + n);
    bad = 0;
    if (lg[fst[1]] != 8'h02) bad++;
    if (lg[fst[1]+1] != a[23:16]) bad++;
    if (lg[fst[1]+2] != a[15:8]) bad++;
    if (lg[fst[1]+3] != a[7:0]) bad++;
    for (int k = 0; k < n; k++) if (lg[fst[1]+4+k] != dbyte(k)) bad++;
    chk(bad == 0, "R3 R5 prog bytes", bad, 0);
    chk(ffall[2] - frise[1] >= WAITC && ffall[2] - frise[1] <= WAITC + 2,
        "R6 settle wait", ffall[2] - frise[1], WAITC);
    bad = 0;
    for (int f = 2; f < nfr && f < 16; f++)
      if (fln[f] != 2 || lg[fst[f]] != 8'h05) bad++;
    chk(bad == 0, "R7 poll frames", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R5 reset pins", int'({cs_n, sclk}), 2);
    chk(dready === 1'b0 && done === 1'b0 && err === 1'b0, "R10 reset outputs",
        int'({dready, done, err}), 0);
    rst_n = 1;
    mon_en = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      run_txn(V_ADDR[v], V_LEN[v], V_BUSY[v], 1'b0);
      verify(V_ADDR[v], V_LEN[v], V_BUSY[v], V_KIND[v]);
    end

    // R10: a bad start strobe in the middle of a job must be ignored
    run_txn(24'h777720, 2, 1, 1'b1);
    verify(24'h777720, 2, 1, 0);
    chk(err_cnt == 0, "R10 start while busy", err_cnt, 0);

    // R1: a full page from offset 1 is one byte too long
    run_txn(24'h000001, 256, 0, 1'b0);
    verify(24'h000001, 256, 0, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule